// File: doc/BRIEF.md
# Recirculating Serial Delay Line

This block is a fixed-length serial shift register. It is used as a time-delay element or as serial storage. On each rising clock edge one bit enters the first stage and every stage hands its bit to the next. A select input chooses where that bit comes from: the main data input or a second recirculation input. Tying the recirculation input to the main output turns the register into a rotating store. The select can also switch between two unrelated serial sources.

The main output is the last full stage. A trailing half stage captures the main output on the falling clock edge, which gives a copy delayed by half a clock period. That copy is meant for cascading when clock edges are slow. A delayed-clock output repeats the input clock with the same polarity through a short buffer path, so a following instance can be clocked from it. Two instances chained through either output behave as one delay line of twice the length. Storage is fully static: when the clock is stopped, high or low, the contents stay as they are.

Top module: `serial_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, all full stages are cleared. The half stage is cleared at the falling edge, so `q` and `q_half` both read 0 afterwards.
- R2: With `sel_recirc` = 0, the value of `din` at a rising edge appears on `q` just after the STAGES-th rising edge, counting that capture edge as the first (STAGES = 64 by default).
- R3: With `sel_recirc` = 1, `rin` is shifted in and `din` has no effect on the stored contents.
- R4: With `sel_recirc` = 1 and `rin` tied to `q`, the contents rotate: `q` repeats with a period of STAGES rising edges.
- R5: `q_half` takes the value of `q` at each falling edge. Between a rising edge and the next falling edge, it still shows the `q` value from before that rising edge.
- R6: `clk_dly` has the same level and polarity as `clk` whenever it is sampled away from an edge.
- R7: With the clock held high or held low for any length of time, `q` and `q_half` keep their values while `din` changes.
- R8: A second instance clocked by `clk_dly`, with its `din` fed from `q` or from `q_half`, delays the first instance's input by 2*STAGES rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge moves data |
| rst | input | 1 | Synchronous active-high clear of all storage |
| din | input | 1 | Main serial data input |
| rin | input | 1 | Recirculation / second source input |
| sel_recirc | input | 1 | 1 selects `rin`, 0 selects `din` |
| q | output | 1 | Last full stage |
| q_half | output | 1 | Half stage, updated on the falling edge |
| clk_dly | output | 1 | Buffered copy of `clk` for cascading |

## Verification
Two functions can act at the same rising edge: in rotation, the bit leaving the last stage is also the bit entering the first stage. The half stage also captures the value the last stage held just before that edge. The bench provokes this by looping `rin` back to `q` while the select is high and the cascaded instances are running. Its reference model derives every captured bit from its own prediction of `q`, never from the design. It then judges `q`, `q_half` and both downstream outputs on every edge. Any off-by-one in the ring length, or a half stage that catches the new value instead of the old one, shows up as a mismatch within one rotation.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic {
    SRC_MAIN   = 1'b0,
    SRC_RECIRC = 1'b1
  } src_e;

  localparam int unsigned DEF_STAGES = 64;
  localparam int unsigned DEF_TAPS   = 2;
endpackage

// File: rtl/sdl_input_mux.sv
module sdl_input_mux
  import sdl_pkg::*;
(
  input  logic main_i,
  input  logic recirc_i,
  input  logic sel_i,
  output logic bit_o
);
  src_e src;

  always_comb begin
    src = src_e'(sel_i);
    case (src)
      SRC_RECIRC: bit_o = recirc_i;
      default:    bit_o = main_i;
    endcase
  end
endmodule

// File: rtl/sdl_stage_chain.sv
module sdl_stage_chain #(
  parameter int unsigned STAGES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_in,
  output logic head_o,
  output logic tail_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] cells;

  always_ff @(posedge clk) begin
    if (rst) cells <= '0;
    else     cells <= {cells[TOP-1:0], shift_in};
  end

  assign head_o = cells[0];
  assign tail_o = cells[TOP];
endmodule

// File: rtl/sdl_half_stage.sv
module sdl_half_stage (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  always_ff @(negedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/sdl_clock_tap.sv
module sdl_clock_tap #(
  parameter int unsigned TAPS = 2
) (
  input  logic clk_i,
  output logic clk_o
);
  logic [TAPS:0] buf_path;

  assign buf_path[0] = clk_i;
  for (genvar gi = 0; gi < TAPS; gi++) begin : g_buf
    assign buf_path[gi+1] = buf_path[gi];
  end
  assign clk_o = buf_path[TAPS];
endmodule

// File: rtl/serial_delay_line.sv
module serial_delay_line #(
  parameter int unsigned STAGES = sdl_pkg::DEF_STAGES,
  parameter int unsigned TAPS   = sdl_pkg::DEF_TAPS
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rin,
  input  logic sel_recirc,
  output logic q,
  output logic q_half,
  output logic clk_dly
);
  logic entry_bit;
  logic head_bit;

  sdl_input_mux u_mux (
    .main_i   (din),
    .recirc_i (rin),
    .sel_i    (sel_recirc),
    .bit_o    (entry_bit)
  );

  sdl_stage_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_in (entry_bit),
    .head_o   (head_bit),
    .tail_o   (q)
  );

  sdl_half_stage u_half (
    .clk (clk),
    .rst (rst),
    .d_i (q),
    .q_o (q_half)
  );

  sdl_clock_tap #(.TAPS(TAPS)) u_tap (
    .clk_i (clk),
    .clk_o (clk_dly)
  );
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker (
  input logic clk,
  input logic rst,
  input logic din,
  input logic rin,
  input logic sel_recirc,
  input logic first_bit,
  input logic q,
  input logic q_half
);
  // R1: a clear at a rising edge empties the last stage
  a_r1_clear_tail: assert property (@(posedge clk) rst |=> (q == 1'b0));

  // R2: main input lands in the first stage when not recirculating
  a_r2_main_entry: assert property (@(posedge clk) disable iff (rst)
    !sel_recirc |=> (first_bit == $past(din)));

  // R3: recirculation input lands in the first stage when selected
  a_r3_recirc_entry: assert property (@(posedge clk) disable iff (rst)
    sel_recirc |=> (first_bit == $past(rin)));

  // R5: half stage holds what the last stage showed at the previous falling edge
  a_r5_half_follow: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> (q_half == $past(q)));
endmodule

bind serial_delay_line sdl_checker u_sdl_checker (
  .clk        (clk),
  .rst        (rst),
  .din        (din),
  .rin        (rin),
  .sel_recirc (sel_recirc),
  .first_bit  (head_bit),
  .q          (q),
  .q_half     (q_half)
);

// File: tb/serial_delay_line_test.sv
`timescale 1ns/1ps
module serial_delay_line_test;
  localparam int STAGES = 64;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic rin_drv = 1'b0;
  logic sel = 1'b0;
  logic loop_en = 1'b0;
  logic rin_w;
  logic q, q_half, clk_dly;
  logic qa, qa_half, qa_clk;
  logic qb, qb_half, qb_clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit hist[$];

  always begin
    #2;
    if (clk_run) clk = ~clk;
  end

  assign rin_w = loop_en ? q : rin_drv;

  serial_delay_line #(.STAGES(STAGES)) uut (
    .clk(clk), .rst(rst), .din(din), .rin(rin_w), .sel_recirc(sel),
    .q(q), .q_half(q_half), .clk_dly(clk_dly)
  );

  serial_delay_line #(.STAGES(STAGES)) cas_a (
    .clk(clk_dly), .rst(rst), .din(q), .rin(1'b0), .sel_recirc(1'b0),
    .q(qa), .q_half(qa_half), .clk_dly(qa_clk)
  );

  serial_delay_line #(.STAGES(STAGES)) cas_b (
    .clk(clk_dly), .rst(rst), .din(q_half), .rin(1'b0), .sel_recirc(1'b0),
    .q(qb), .q_half(qb_half), .clk_dly(qb_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_at(input int lag);
    if (hist.size() >= lag) return hist[hist.size() - lag];
    return 1'b0;
  endfunction

  // one rising edge (and optionally the following falling edge), all outputs judged
  task automatic step(input bit d, input bit s, input bit r, input bit to_low = 1'b1);
    bit cap, qprev;
    din = d; sel = s; rin_drv = r;
    qprev = exp_at(STAGES);
    cap = s ? (loop_en ? qprev : r) : d;
    @(posedge clk); #1;
    hist.push_back(cap);
    chk(q == exp_at(STAGES), "R2/R3/R4 q", q, exp_at(STAGES));
    chk(q_half == qprev, "R5 q_half before fall", q_half, qprev);
    chk(clk_dly == 1'b1, "R6 clk_dly high", clk_dly, 1);
    chk(qa == exp_at(2*STAGES), "R8 cascade via q", qa, exp_at(2*STAGES));
    chk(qb == exp_at(2*STAGES), "R8 cascade via q_half", qb, exp_at(2*STAGES));
    if (to_low) begin
      @(negedge clk); #1;
      chk(q_half == exp_at(STAGES), "R5 q_half after fall", q_half, exp_at(STAGES));
      chk(clk_dly == 1'b0, "R6 clk_dly low", clk_dly, 0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; din = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(q == 1'b0, "R1 q cleared", q, 0);
    chk(q_half == 1'b0, "R1 q_half cleared", q_half, 0);
    chk(qa == 1'b0 && qb == 1'b0, "R1 cascade cleared", {qa, qb}, 0);
    rst = 1'b0;
    hist.delete();
    for (int i = 0; i < STAGES + 4; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_main();
    for (int i = 0; i < 3*STAGES; i++) step(((i * 7) % 5) < 2, 1'b0, 1'b1);
  endtask

  task automatic t_second_source();
    for (int i = 0; i < STAGES + 20; i++) begin
      bit r = ((i % 3) == 0);
      step(~r, 1'b1, r);
    end
  endtask

  task automatic t_rotate();
    bit snap;
    for (int i = 0; i < STAGES; i++) step(((i % 5) == 1) || (i == 7), 1'b0, 1'b0);
    loop_en = 1'b1;
    snap = q;
    for (int i = 0; i < STAGES; i++) step(~din, 1'b1, 1'b0);
    chk(q == snap, "R4 rotation period", q, snap);
    for (int i = 0; i < STAGES + 10; i++) step(i[0], 1'b1, 1'b1);
    loop_en = 1'b0;
  endtask

  task automatic t_static();
    bit hq, hh;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    clk_run = 1'b0;
    hq = q; hh = q_half;
    for (int i = 0; i < 20; i++) begin din = ~din; #7; end
    chk(q == hq && q_half == hh && clk == 1'b1, "R7 hold clock high", {q, q_half}, {hq, hh});
    clk_run = 1'b1;
    @(negedge clk); #1;
    chk(q_half == exp_at(STAGES), "R5 q_half after restart", q_half, exp_at(STAGES));
    step(1'b0, 1'b0, 1'b0);
    clk_run = 1'b0;
    hq = q; hh = q_half;
    for (int i = 0; i < 20; i++) begin din = ~din; #7; end
    chk(q == hq && q_half == hh && clk == 1'b0, "R7 hold clock low", {q, q_half}, {hq, hh});
    clk_run = 1'b1;
    for (int i = 0; i < STAGES + 8; i++) step(i[1], 1'b0, 1'b0);
  endtask

  task automatic t_reset_loaded();
    rst = 1'b1;
    @(posedge clk); #1;
    chk(q == 1'b0, "R1 clear with data loaded", q, 0);
    @(negedge clk); #1;
    chk(q_half == 1'b0, "R1 half clear with data loaded", q_half, 0);
    rst = 1'b0;
    hist.delete();
    for (int i = 0; i < STAGES; i++) step(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #2;
    t_reset();
    t_main();
    t_second_source();
    t_rotate();
    t_static();
    t_reset_loaded();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule